// File: doc/BRIEF.md
# Two-Source Vectored Interrupt Controller

This block sits beside a small microcontroller core and decides when the running program should be diverted to an interrupt handler. It watches two external request lines. A request counts only when the global enable and that source's own enable are both set. Each source carries one priority bit that places it at the high or the low level. Requests are judged only when the core signals an instruction boundary, so an instruction is never split.

When a request is accepted, the block raises a one-cycle take pulse and presents a fixed 16-bit handler address. Source 0 goes to 0003h and source 1 goes to 000Bh, so each handler slot has 8 bytes. Before the first acceptance after reset the address output shows the reset start address 0000h. In the same cycle as the take pulse, the block sends a one-cycle clear pulse back to the request flag of the accepted source.

Two in-service bits, one per priority level, record which handlers are active. A high-priority request may interrupt a running low-priority handler. A request at the same or a lower level than an active handler waits. The return strobe clears the highest in-service level that is set. Saving context, fetching instructions and stack storage belong to the core.

Top module: `irq2v_ctrl`

## Requirements
- R1: After synchronous reset, take_o is 0, ack_clr_o is 00 and vec_addr_o is 0000h, and no handler is in service. A low-priority request is therefore accepted at the first boundary.
- R2: A request is acted on only in a cycle where insn_bnd_i is 1. take_o rises in the cycle after that boundary cycle, and never without one.
- R3: Source 0 (bit 0 of every per-source bus) yields vec_addr_o = 0003h and source 1 (bit 1) yields 000Bh. vec_addr_o changes only when a request is accepted and otherwise holds its value.
- R4: A request is considered only when glob_en_i is 1 and the source's bit in src_en_i is 1. Otherwise there is no take_o and no ack_clr_o.
- R5: When both sources request at the same priority at the same boundary, source 0 is accepted.
- R6: src_hi_i bit = 1 marks a source as high priority. At the same boundary, a high-priority request is accepted before a low-priority one, whatever their indices.
- R7: A high-priority request is accepted while only a low-priority handler is in service, so the handlers nest.
- R8: While a high-priority handler is in service, no request is accepted. While a low-priority handler alone is in service, no low-priority request is accepted. Such requests are accepted after the return strobe.
- R9: ack_clr_o is one-hot, carries the bit of the accepted source, and is nonzero only in the cycle where take_o is 1.
- R10: reti_i clears the high in-service level if it is set, and otherwise clears the low level. After one return from a nested pair, a low request still waits and a high request is accepted.
- R11: Each acceptance produces a single-cycle take_o pulse, and at most one source is accepted per boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 2 | Interrupt request lines, bit n is source n |
| src_en_i | input | 2 | Per-source enable |
| src_hi_i | input | 2 | Per-source priority, 1 = high |
| glob_en_i | input | 1 | Global interrupt enable |
| insn_bnd_i | input | 1 | Instruction-boundary strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| take_o | output | 1 | One-cycle pulse: divert to handler |
| vec_addr_o | output | 16 | Handler address of the last accepted source |
| ack_clr_o | output | 2 | One-cycle request-clear pulse to the accepted source |

## Verification
Directed patterns cover each source alone, both sources together at equal and at differing levels, and gated requests. These separate the fixed index order from the priority order and from the enable gating. Nested sequences run low then high, with returns placed between further requests, to show which in-service level a return clears and which requests must wait. A long seeded random stream mixes requests, enables, levels, boundaries and returns, and a bench model predicts every cycle. This exposes timing slips around boundaries and interactions between a return and an acceptance in the same cycle.

// File: rtl/irq2v_pkg.sv
package irq2v_pkg;

    localparam int SRC_CNT   = 2;
    localparam int SRC_IDX_W = 1;
    localparam int VEC_W     = 16;

    localparam logic [VEC_W-1:0] START_VEC = 16'h0000;
    localparam logic [VEC_W-1:0] VEC_BASE  = 16'h0003;
    localparam logic [VEC_W-1:0] VEC_STEP  = 16'h0008;

    typedef enum logic {
        LVL_LO = 1'b0,
        LVL_HI = 1'b1
    } lvl_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } isr_t;

    function automatic logic [VEC_W-1:0] vec_of(input logic [SRC_IDX_W-1:0] idx);
        return VEC_BASE + VEC_STEP * VEC_W'(idx);
    endfunction

endpackage

// File: rtl/irq2v_qualify.sv
module irq2v_qualify
    import irq2v_pkg::*;
#(
    parameter int NSRC = SRC_CNT
) (
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] en,
    input  logic [NSRC-1:0] hi,
    input  logic            glob,
    input  isr_t            isr,
    output logic [NSRC-1:0] cand_hi,
    output logic [NSRC-1:0] cand_lo
);

    logic hi_open;
    logic lo_open;

    assign hi_open = !isr.hi;
    assign lo_open = !isr.hi && !isr.lo;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic live;
        assign live       = req[g] && en[g] && glob;
        assign cand_hi[g] = live && hi[g]  && hi_open;
        assign cand_lo[g] = live && !hi[g] && lo_open;
    end

endmodule

// File: rtl/irq2v_pick.sv
module irq2v_pick
    import irq2v_pkg::*;
#(
    parameter int NSRC  = SRC_CNT,
    parameter int IDX_W = SRC_IDX_W
) (
    input  logic [NSRC-1:0]  cand_hi,
    input  logic [NSRC-1:0]  cand_lo,
    output logic             gnt_vld,
    output logic [IDX_W-1:0] gnt_idx,
    output lvl_e             gnt_lvl
);

    always_comb begin
        gnt_idx = '0;
        gnt_lvl = LVL_LO;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (cand_lo[i]) begin
                gnt_idx = IDX_W'(i);
                gnt_lvl = LVL_LO;
            end
        end
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (cand_hi[i]) begin
                gnt_idx = IDX_W'(i);
                gnt_lvl = LVL_HI;
            end
        end
        gnt_vld = (|cand_hi) || (|cand_lo);
    end

    // R11
    always_comb begin
        one_grant_chk: assert (!gnt_vld || cand_hi[gnt_idx] || cand_lo[gnt_idx]);
    end

endmodule

// File: rtl/irq2v_inservice.sv
module irq2v_inservice
    import irq2v_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_en,
    input  lvl_e set_lvl,
    input  logic reti,
    output isr_t isr
);

    isr_t isr_nxt;

    always_comb begin
        isr_nxt = isr;
        if (reti) begin
            if (isr.hi) isr_nxt.hi = 1'b0;
            else        isr_nxt.lo = 1'b0;
        end
        if (set_en) begin
            if (set_lvl == LVL_HI) isr_nxt.hi = 1'b1;
            else                   isr_nxt.lo = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) isr <= '0;
        else     isr <= isr_nxt;
    end

    // R10
    hi_first_chk: assert property (@(posedge clk) disable iff (rst)
        (reti && isr.hi && isr.lo && !set_en) |=> (!isr.hi && isr.lo));

    // R7
    hi_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (set_en && set_lvl == LVL_HI) |-> !isr.hi);

    // R8
    lo_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (set_en && set_lvl == LVL_LO) |-> (!isr.hi && !isr.lo));

endmodule

// File: rtl/irq2v_ctrl.sv
module irq2v_ctrl
    import irq2v_pkg::*;
#(
    parameter int NSRC  = SRC_CNT,
    parameter int IDX_W = SRC_IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  req_i,
    input  logic [NSRC-1:0]  src_en_i,
    input  logic [NSRC-1:0]  src_hi_i,
    input  logic             glob_en_i,
    input  logic             insn_bnd_i,
    input  logic             reti_i,
    output logic             take_o,
    output logic [VEC_W-1:0] vec_addr_o,
    output logic [NSRC-1:0]  ack_clr_o
);

    isr_t             isr;
    logic [NSRC-1:0]  cand_hi;
    logic [NSRC-1:0]  cand_lo;
    logic             gnt_vld;
    logic [IDX_W-1:0] gnt_idx;
    lvl_e             gnt_lvl;
    logic             accept;

    irq2v_qualify #(.NSRC(NSRC)) qual_i (
        .req     (req_i),
        .en      (src_en_i),
        .hi      (src_hi_i),
        .glob    (glob_en_i),
        .isr     (isr),
        .cand_hi (cand_hi),
        .cand_lo (cand_lo)
    );

    irq2v_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) pick_i (
        .cand_hi (cand_hi),
        .cand_lo (cand_lo),
        .gnt_vld (gnt_vld),
        .gnt_idx (gnt_idx),
        .gnt_lvl (gnt_lvl)
    );

    assign accept = insn_bnd_i && gnt_vld;

    irq2v_inservice isv_i (
        .clk     (clk),
        .rst     (rst),
        .set_en  (accept),
        .set_lvl (gnt_lvl),
        .reti    (reti_i),
        .isr     (isr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            take_o     <= 1'b0;
            ack_clr_o  <= '0;
            vec_addr_o <= START_VEC;
        end else begin
            take_o    <= accept;
            ack_clr_o <= accept ? (NSRC'(1) << gnt_idx) : '0;
            if (accept) vec_addr_o <= vec_of(gnt_idx);
        end
    end

    // R2
    bnd_only_chk: assert property (@(posedge clk) disable iff (rst)
        take_o |-> $past(insn_bnd_i));

    // R9
    ack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        take_o |-> $onehot(ack_clr_o));

    // R9
    ack_with_take_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_clr_o != '0) |-> take_o);

    // R3
    vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !take_o && !$past(rst) |-> $stable(vec_addr_o));

endmodule

// File: tb/irq2v_ctrl_tb_top.sv
module irq2v_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  req_i, src_en_i, src_hi_i;
    logic        glob_en_i, insn_bnd_i, reti_i;
    logic        take_o;
    logic [15:0] vec_addr_o;
    logic [1:0]  ack_clr_o;

    int checks = 0;
    int fails  = 0;
    bit m_hi = 0, m_lo = 0;
    logic [15:0] m_vec = 16'h0000;

    always #5 clk = ~clk;

    irq2v_ctrl dut_i (
        .clk(clk), .rst(rst), .req_i(req_i), .src_en_i(src_en_i),
        .src_hi_i(src_hi_i), .glob_en_i(glob_en_i), .insn_bnd_i(insn_bnd_i),
        .reti_i(reti_i), .take_o(take_o), .vec_addr_o(vec_addr_o),
        .ack_clr_o(ack_clr_o)
    );

    function automatic logic [15:0] exp_vec(input int idx);
        return (idx == 0) ? 16'h0003 : 16'h000B;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag, input logic [1:0] rq, input logic [1:0] en,
                        input logic [1:0] hi, input logic gl, input logic bnd,
                        input logic rt);
        logic [1:0] elig, ch, cl;
        int idx;
        bit lvl_hi, tk;
        logic [1:0] ack;
        req_i = rq; src_en_i = en; src_hi_i = hi;
        glob_en_i = gl; insn_bnd_i = bnd; reti_i = rt;
        elig = rq & en & {2{gl}};
        ch = elig & hi & {2{!m_hi}};
        cl = elig & ~hi & {2{!m_hi && !m_lo}};
        idx = 0; lvl_hi = 0;
        if (ch[0]) begin idx = 0; lvl_hi = 1; end
        else if (ch[1]) begin idx = 1; lvl_hi = 1; end
        else if (cl[0]) idx = 0;
        else if (cl[1]) idx = 1;
        tk = bnd && ((ch | cl) != 2'b00);
        ack = tk ? (2'b01 << idx) : 2'b00;
        if (tk) m_vec = exp_vec(idx);
        @(posedge clk);
        @(negedge clk);
        chk(tag, "take", 32'(take_o), 32'(tk));
        chk(tag, "ack", 32'(ack_clr_o), 32'(ack));
        chk(tag, "vec", 32'(vec_addr_o), 32'(m_vec));
        if (rt) begin
            if (m_hi) m_hi = 0; else m_lo = 0;
        end
        if (tk) begin
            if (lvl_hi) m_hi = 1; else m_lo = 1;
        end
    endtask

    task automatic idle(input string tag);
        step(tag, 2'b00, 2'b11, 2'b00, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic ret(input string tag);
        step(tag, 2'b00, 2'b11, 2'b00, 1'b1, 1'b0, 1'b1);
    endtask

    bit done = 0;

    initial begin
        #2_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        process::self().srandom(32'd2024);
        rst = 1; req_i = 0; src_en_i = 0; src_hi_i = 0;
        glob_en_i = 0; insn_bnd_i = 0; reti_i = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "take", 32'(take_o), 0);
        chk("R1", "ack", 32'(ack_clr_o), 0);
        chk("R1", "vec", 32'(vec_addr_o), 32'h0000);
        rst = 0;
        // R1: nothing in service, low request accepted first
        step("R1", 2'b01, 2'b11, 2'b00, 1, 1, 0);
        ret("R1");
        // R3: vectors
        step("R3", 2'b10, 2'b11, 2'b00, 1, 1, 0);
        ret("R3");
        step("R3", 2'b01, 2'b11, 2'b00, 1, 1, 0);
        idle("R3");
        ret("R3");
        // R2: no boundary, no take
        step("R2", 2'b01, 2'b11, 2'b00, 1, 0, 0);
        step("R2", 2'b10, 2'b11, 2'b11, 1, 0, 0);
        // R4: gating
        step("R4", 2'b11, 2'b11, 2'b00, 0, 1, 0);
        step("R4", 2'b01, 2'b10, 2'b00, 1, 1, 0);
        step("R4", 2'b10, 2'b01, 2'b10, 1, 1, 0);
        // R5: equal priority tie
        step("R5", 2'b11, 2'b11, 2'b00, 1, 1, 0);
        ret("R5");
        step("R5", 2'b11, 2'b11, 2'b11, 1, 1, 0);
        ret("R5");
        // R6: high beats low regardless of index
        step("R6", 2'b11, 2'b11, 2'b10, 1, 1, 0);
        ret("R6");
        // R7 and R10: nesting then ordered returns
        step("R7", 2'b01, 2'b11, 2'b00, 1, 1, 0);
        step("R7", 2'b10, 2'b11, 2'b10, 1, 1, 0);
        ret("R10");
        step("R10", 2'b01, 2'b11, 2'b00, 1, 1, 0);
        step("R10", 2'b10, 2'b11, 2'b10, 1, 1, 0);
        ret("R10");
        ret("R10");
        step("R10", 2'b01, 2'b11, 2'b00, 1, 1, 0);
        ret("R10");
        // R8: blocking by active handlers
        step("R8", 2'b01, 2'b11, 2'b01, 1, 1, 0);
        step("R8", 2'b10, 2'b11, 2'b11, 1, 1, 0);
        step("R8", 2'b10, 2'b11, 2'b00, 1, 1, 0);
        ret("R8");
        step("R8", 2'b10, 2'b11, 2'b10, 1, 1, 0);
        ret("R8");
        step("R8", 2'b01, 2'b11, 2'b00, 1, 1, 0);
        step("R8", 2'b10, 2'b11, 2'b00, 1, 1, 0);
        ret("R8");
        // R9 and R11: single pulse, ack follows source
        step("R9", 2'b10, 2'b11, 2'b00, 1, 1, 0);
        step("R11", 2'b10, 2'b11, 2'b00, 1, 0, 0);
        idle("R11");
        ret("R9");
        // Random mix checked against the model
        for (int n = 0; n < 4000; n++) begin
            logic [1:0] rq, en, hi;
            logic gl, bnd, rt;
            rq  = 2'($urandom);
            en  = ($urandom % 4 == 0) ? 2'($urandom) : 2'b11;
            hi  = 2'($urandom);
            gl  = ($urandom % 8) != 0;
            bnd = $urandom % 2;
            rt  = ($urandom % 6) == 0;
            step("RND", rq, en, hi, gl, bnd, rt);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule